// File: doc/BRIEF.md
# Long Register Pair Mover

This block holds two 56-bit accumulators and two 48-bit input registers and moves a 48-bit long word into or out of them. Each accumulator is an 8-bit extension on top of a high 24-bit word and a low 24-bit word. Each input register is a high word and a low word. One write port and one read port each take a 3-bit pair selector. The selector picks one of three kinds of access: a raw access to the two words of one register, a full accumulator access, or a packed access that places the high words of both accumulators in one long word.

Full and packed reads pass each accumulator through a limiter. An accumulator whose extension disagrees with bit 47 is replaced by the largest value of matching sign. Full and packed writes rebuild the extension from the sign of the written word, and packed writes also clear the low word. Read data and the limit flag are registered, so they appear one clock after the read is requested. All four registers are visible as outputs for the neighbouring datapath.

Top module: `lreg_pair_mover`

## Requirements
- R1: Read selector codes are 000 = A high:low, 001 = B high:low, 010 = X, 011 = Y. These codes return the 48 stored bits unchanged, with no limiting, on `rd_data_o` one clock after `rd_en_i`.
- R2: Writes with codes 000 to 011 load exactly 48 bits. The extension of A or B is left untouched, and no other register changes.
- R3: A write with code 100 (A) or 101 (B) loads the high and low words and fills the 8-bit extension with copies of data bit 47.
- R4: A read with code 100 or 101 returns bits 47:0 when bits 55:47 of the accumulator are all equal. Otherwise it returns 0x7FFFFFFFFFFF when bit 55 is 0, or 0x800000000000 when bit 55 is 1.
- R5: A write with code 110 places data bits 47:24 in the high word of A and data bits 23:0 in the high word of B. It sign-extends each accumulator's extension from its new high word and clears both low words.
- R6: A write with code 111 does the same as code 110 with the accumulators swapped: B receives bits 47:24 and A receives bits 23:0.
- R7: A read with code 110 returns {A', B'}, and a read with code 111 returns {B', A'}. Each primed value is that accumulator's high word, or 0x7FFFFF / 0x800000 under the overflow rule of R4, applied to each accumulator on its own.
- R8: `lim_o` is high for exactly the one cycle in which the data of a read that saturated anything appears. It is low at all other times.
- R9: A read and a write issued in the same cycle with the same selector return the value held before the write.
- R10: While reset is asserted, all registers and outputs are zero.
- R11: `rd_data_o` holds its last value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_sel_i | input | 3 | Write pair selector |
| wr_data_i | input | 48 | Long word to write |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 3 | Read pair selector |
| rd_data_o | output | 48 | Registered read data |
| lim_o | output | 1 | Saturation occurred in the last read |
| acc_a_o | output | 56 | Accumulator A |
| acc_b_o | output | 56 | Accumulator B |
| x_o | output | 48 | Input register X |
| y_o | output | 48 | Input register Y |

## Verification
Several properties are checked on every cycle:
- The full writes rebuild the extension from the written sign.
- A packed write clears both low words.
- A raw write keeps the extension and leaves the other accumulator alone.
- The limit flag rises only after a read, and never after a raw read.
- The read data holds while no read is requested.

The value limiting on full and packed reads needs accumulator contents that have been prepared in advance. The half ordering of codes 110 and 111, and the same-cycle read-before-write case, also depend on such contents. These behaviours are shown only by the bench's directed scenarios.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    SEL_A_RAW = 3'b000,
    SEL_B_RAW = 3'b001,
    SEL_X     = 3'b010,
    SEL_Y     = 3'b011,
    SEL_A     = 3'b100,
    SEL_B     = 3'b101,
    SEL_AB    = 3'b110,
    SEL_BA    = 3'b111
  } pair_sel_e;
endpackage

// File: rtl/lpm_limiter.sv
// Saturates a signed value whose top EXT_W+1 bits are not uniform.
module lpm_limiter #(
  parameter int EXT_W = 8,
  parameter int OUT_W = 48,
  localparam int IN_W = EXT_W + OUT_W
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o,
  output logic             ovf_o
);
  logic [EXT_W:0] top;
  logic           sign;

  assign top  = val_i[IN_W-1:OUT_W-1];
  assign sign = val_i[IN_W-1];

  always_comb begin
    ovf_o = !((top == '0) || (top == '1));
    if (ovf_o) val_o = {sign, {(OUT_W-1){~sign}}};
    else       val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/lpm_regfile.sv
module lpm_regfile
  import lpm_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8,
  localparam int LONG_W = 2 * WORD_W,
  localparam int ACC_W  = EXT_W + LONG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [LONG_W-1:0] wr_data_i,
  output logic [ACC_W-1:0]  acc_a_o,
  output logic [ACC_W-1:0]  acc_b_o,
  output logic [LONG_W-1:0] x_o,
  output logic [LONG_W-1:0] y_o
);
  logic [ACC_W-1:0]  a_q, a_d, b_q, b_d;
  logic [LONG_W-1:0] x_q, x_d, y_q, y_d;
  logic [WORD_W-1:0] hi_w, lo_w;
  logic [ACC_W-1:0]  full_w, hi_pack, lo_pack;
  pair_sel_e         sel;

  assign sel     = pair_sel_e'(wr_sel_i);
  assign hi_w    = wr_data_i[LONG_W-1:WORD_W];
  assign lo_w    = wr_data_i[WORD_W-1:0];
  assign full_w  = {{EXT_W{wr_data_i[LONG_W-1]}}, wr_data_i};
  assign hi_pack = {{EXT_W{hi_w[WORD_W-1]}}, hi_w, {WORD_W{1'b0}}};
  assign lo_pack = {{EXT_W{lo_w[WORD_W-1]}}, lo_w, {WORD_W{1'b0}}};

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    x_d = x_q;
    y_d = y_q;
    if (wr_en_i) begin
      unique case (sel)
        SEL_A_RAW: a_d = {a_q[ACC_W-1:LONG_W], wr_data_i};
        SEL_B_RAW: b_d = {b_q[ACC_W-1:LONG_W], wr_data_i};
        SEL_X:     x_d = wr_data_i;
        SEL_Y:     y_d = wr_data_i;
        SEL_A:     a_d = full_w;
        SEL_B:     b_d = full_w;
        SEL_AB: begin
          a_d = hi_pack;
          b_d = lo_pack;
        end
        SEL_BA: begin
          b_d = hi_pack;
          a_d = lo_pack;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
      x_q <= '0;
      y_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
  assign x_o     = x_q;
  assign y_o     = y_q;
endmodule

// File: rtl/lpm_read_mux.sv
module lpm_read_mux
  import lpm_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8,
  localparam int LONG_W = 2 * WORD_W,
  localparam int ACC_W  = EXT_W + LONG_W
) (
  input  logic [2:0]        sel_i,
  input  logic [ACC_W-1:0]  acc_a_i,
  input  logic [ACC_W-1:0]  acc_b_i,
  input  logic [LONG_W-1:0] x_i,
  input  logic [LONG_W-1:0] y_i,
  output logic [LONG_W-1:0] data_o,
  output logic              sat_o
);
  logic [ACC_W-1:0]  acc [2];
  logic [LONG_W-1:0] full_v [2];
  logic [WORD_W-1:0] half_v [2];
  logic [1:0]        full_ovf, half_ovf;
  pair_sel_e         sel;

  assign acc[0] = acc_a_i;
  assign acc[1] = acc_b_i;
  assign sel    = pair_sel_e'(sel_i);

  for (genvar g = 0; g < 2; g++) begin : g_acc
    lpm_limiter #(.EXT_W(EXT_W), .OUT_W(LONG_W)) u_full (
      .val_i(acc[g]),
      .val_o(full_v[g]),
      .ovf_o(full_ovf[g])
    );
    lpm_limiter #(.EXT_W(EXT_W), .OUT_W(WORD_W)) u_half (
      .val_i(acc[g][ACC_W-1:WORD_W]),
      .val_o(half_v[g]),
      .ovf_o(half_ovf[g])
    );
  end

  always_comb begin
    data_o = '0;
    sat_o  = 1'b0;
    unique case (sel)
      SEL_A_RAW: data_o = acc_a_i[LONG_W-1:0];
      SEL_B_RAW: data_o = acc_b_i[LONG_W-1:0];
      SEL_X:     data_o = x_i;
      SEL_Y:     data_o = y_i;
      SEL_A: begin
        data_o = full_v[0];
        sat_o  = full_ovf[0];
      end
      SEL_B: begin
        data_o = full_v[1];
        sat_o  = full_ovf[1];
      end
      SEL_AB: begin
        data_o = {half_v[0], half_v[1]};
        sat_o  = |half_ovf;
      end
      SEL_BA: begin
        data_o = {half_v[1], half_v[0]};
        sat_o  = |half_ovf;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lreg_pair_mover.sv
module lreg_pair_mover #(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8,
  localparam int LONG_W = 2 * WORD_W,
  localparam int ACC_W  = EXT_W + LONG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [LONG_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_sel_i,
  output logic [LONG_W-1:0] rd_data_o,
  output logic              lim_o,
  output logic [ACC_W-1:0]  acc_a_o,
  output logic [ACC_W-1:0]  acc_b_o,
  output logic [LONG_W-1:0] x_o,
  output logic [LONG_W-1:0] y_o
);
  logic [ACC_W-1:0]  acc_a, acc_b;
  logic [LONG_W-1:0] x_r, y_r, mux_data, rd_q;
  logic              mux_sat, lim_q;

  lpm_regfile #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .acc_a_o   (acc_a),
    .acc_b_o   (acc_b),
    .x_o       (x_r),
    .y_o       (y_r)
  );

  // Reads see pre-write register state; the write lands on the same edge.
  lpm_read_mux #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_rmux (
    .sel_i   (rd_sel_i),
    .acc_a_i (acc_a),
    .acc_b_i (acc_b),
    .x_i     (x_r),
    .y_i     (y_r),
    .data_o  (mux_data),
    .sat_o   (mux_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      lim_q <= 1'b0;
    end else begin
      lim_q <= rd_en_i & mux_sat;
      if (rd_en_i) rd_q <= mux_data;
    end
  end

  assign rd_data_o = rd_q;
  assign lim_o     = lim_q;
  assign acc_a_o   = acc_a;
  assign acc_b_o   = acc_b;
  assign x_o       = x_r;
  assign y_o       = y_r;
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk #(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8,
  localparam int LONG_W = 2 * WORD_W,
  localparam int ACC_W  = EXT_W + LONG_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        wr_sel_i,
  input logic [LONG_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [2:0]        rd_sel_i,
  input logic [LONG_W-1:0] rd_data_o,
  input logic              lim_o,
  input logic [ACC_W-1:0]  acc_a_o,
  input logic [ACC_W-1:0]  acc_b_o
);
  // R3
  full_a_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'b100) |=>
      acc_a_o == {{EXT_W{$past(wr_data_i[LONG_W-1])}}, $past(wr_data_i)});

  // R5
  pack_clear_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i[2:1] == 2'b11) |=>
      (acc_a_o[WORD_W-1:0] == '0) && (acc_b_o[WORD_W-1:0] == '0));

  // R2
  raw_keep_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 3'b000) |=>
      $stable(acc_a_o[ACC_W-1:LONG_W]) && $stable(acc_b_o));

  // R8
  lim_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_o |-> $past(rd_en_i) && $past(rd_sel_i[2]));

  // R1
  raw_no_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i[2]) |=> !lim_o);

  // R11
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind lreg_pair_mover lpm_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .lim_o     (lim_o),
  .acc_a_o   (acc_a_o),
  .acc_b_o   (acc_b_o)
);

// File: tb/lreg_pair_mover_tb.sv
`timescale 1ns/1ps
module lreg_pair_mover_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [47:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [2:0]  rd_sel_i = '0;
  logic [47:0] rd_data_o;
  logic        lim_o;
  logic [55:0] acc_a_o, acc_b_o;
  logic [47:0] x_o, y_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  lreg_pair_mover u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .lim_o(lim_o),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .x_o(x_o), .y_o(y_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [47:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [47:0] exp_d, input logic exp_l,
                    input string req);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_sel_i = sel;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(req, {16'h0, rd_data_o}, {16'h0, exp_d});
    check({req, " R8 flag"}, {63'h0, lim_o}, {63'h0, exp_l});
  endtask

  task automatic t_reset;
    // R10
    check("R10 rd", {16'h0, rd_data_o}, '0);
    check("R10 lim", {63'h0, lim_o}, '0);
    check("R10 a", {8'h0, acc_a_o}, '0);
    check("R10 b", {8'h0, acc_b_o}, '0);
    check("R10 x", {16'h0, x_o}, '0);
    check("R10 y", {16'h0, y_o}, '0);
  endtask

  task automatic t_raw;
    wr(3'b000, 48'h123456_789ABC);
    check("R2 a raw", {8'h0, acc_a_o}, 64'h00_123456_789ABC);
    rd(3'b000, 48'h123456_789ABC, 1'b0, "R1 a raw");
    wr(3'b010, 48'hA5A5A5_5A5A5A);
    wr(3'b011, 48'h000001_FFFFFF);
    check("R2 x", {16'h0, x_o}, 64'hA5A5A5_5A5A5A);
    check("R2 y", {16'h0, y_o}, 64'h000001_FFFFFF);
    check("R2 a untouched", {8'h0, acc_a_o}, 64'h00_123456_789ABC);
    rd(3'b010, 48'hA5A5A5_5A5A5A, 1'b0, "R1 x");
    rd(3'b011, 48'h000001_FFFFFF, 1'b0, "R1 y");
    wr(3'b001, 48'hFEDCBA_987654);
    check("R2 b raw", {8'h0, acc_b_o}, 64'h00_FEDCBA_987654);
    rd(3'b001, 48'hFEDCBA_987654, 1'b0, "R1 b raw no limit");
  endtask

  task automatic t_full;
    wr(3'b100, 48'h800000_000001);
    check("R3 a sext", {8'h0, acc_a_o}, 64'hFF_800000_000001);
    rd(3'b100, 48'h800000_000001, 1'b0, "R4 a in range");
    wr(3'b000, 48'h000000_000005);
    check("R2 keep ext", {8'h0, acc_a_o}, 64'hFF_000000_000005);
    rd(3'b000, 48'h000000_000005, 1'b0, "R1 raw ovf no limit");
    rd(3'b100, 48'h800000_000000, 1'b1, "R4 neg sat");
    @(negedge clk_i);
    check("R8 pulse ends", {63'h0, lim_o}, '0);
    check("R11 hold", {16'h0, rd_data_o}, 64'h800000_000000);
    wr(3'b101, 48'h0);
    wr(3'b001, 48'h800000_000000);
    rd(3'b101, 48'h7FFFFF_FFFFFF, 1'b1, "R4 pos sat");
  endtask

  task automatic t_pack;
    wr(3'b110, 48'h812345_00ABCD);
    check("R5 a", {8'h0, acc_a_o}, 64'hFF_812345_000000);
    check("R5 b", {8'h0, acc_b_o}, 64'h00_00ABCD_000000);
    rd(3'b110, 48'h812345_00ABCD, 1'b0, "R7 ab");
    rd(3'b111, 48'h00ABCD_812345, 1'b0, "R7 ba");
    wr(3'b111, 48'h7FFFFF_FFFFFE);
    check("R6 b", {8'h0, acc_b_o}, 64'h00_7FFFFF_000000);
    check("R6 a", {8'h0, acc_a_o}, 64'hFF_FFFFFE_000000);
    wr(3'b100, 48'h0);
    wr(3'b000, 48'h800000_000000);
    wr(3'b101, 48'h123456_000000);
    rd(3'b110, 48'h7FFFFF_123456, 1'b1, "R7 ab a sat");
    rd(3'b111, 48'h123456_7FFFFF, 1'b1, "R7 ba a sat");
    wr(3'b101, 48'hFFFFFF_FFFFFF);
    wr(3'b001, 48'h0);
    rd(3'b111, 48'h800000_7FFFFF, 1'b1, "R7 both sat");
  endtask

  task automatic t_collide;
    wr(3'b100, 48'h000111_222333);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_sel_i = 3'b100;
    wr_en_i = 1'b1; wr_sel_i = 3'b100; wr_data_i = 48'hFFF000_000000;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    check("R9 old value", {16'h0, rd_data_o}, 64'h000111_222333);
    check("R9 write done", {8'h0, acc_a_o}, 64'hFF_FFF000_000000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_raw;
    t_full;
    t_pack;
    t_collide;
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule